// File: doc/BRIEF.md
# Multi-issue reorder buffer with register renaming

This block is the in-order bookkeeping core of a small out-of-order machine. It is a circular buffer of 16 entries. Each cycle it can open up to four entries for newly dispatched micro-ops, in program order, and hands back the tag of each entry. Every entry holds the destination architectural register, the instruction's program counter and, once it is known, the result. Execution units return results out of order by tag. Each accepted result is written into its entry and is also driven, in the same cycle, on a forwarding bus that every consumer can watch.

Two lookup ports rename source operands. A lookup returns the youngest in-flight copy of the requested register when that copy has its value. When that copy is still waiting for its value, the lookup returns the entry's tag in its place. When nothing in flight targets the register, the lookup reads the committed register file. Completed entries leave from the oldest end, up to four per cycle, and update an eight-register architectural file. If two or more of the leaving entries name the same register, only the youngest of them is committed. A branch mispredict cuts the buffer back to the branch's own entry and does not touch the committed registers.

Top module: `rob_rename`

## Requirements
- R1: After reset the buffer is empty, the first tag handed out is 0, all eight architectural registers read 0 and `retireCnt` is 0.
- R2: A request of `allocCount` (0 to 4) entries receives the consecutive tags tail, tail+1, and so on, modulo 16. Lane i of `allocDest`/`allocPc` belongs to the i-th oldest of the new entries.
- R3: `allocStall` is high exactly when `allocCount` exceeds the number of free entries. While it is high, no entry is allocated and the tail does not move.
- R4: A completion whose tag names a live entry stores its value and marks the entry done, whatever the order of completions. A completion whose tag names no live entry is ignored.
- R5: In the same cycle as an accepted completion, `fwdValid` is 1 and `fwdTag`/`fwdData` repeat its tag and value. For an ignored completion, `fwdValid` is 0.
- R6: A lookup whose register is the destination of a live entry answers from the youngest such entry. If that entry is done, the answer is `lkReady`=1 with its value. Otherwise the answer is `lkReady`=0 with its tag on `lkTag`.
- R7: A lookup whose register no live entry targets answers `lkReady`=1 with the architectural register's value.
- R8: Each cycle, `retireCnt` entries leave from the head. This is the length of the run of done entries that starts at the head, capped at 4. The leaving entries write their results into the architectural file.
- R9: When several entries that leave in the same cycle target one register, that register ends with the value of the youngest of them.
- R10: `flushValid` with `flushTag` discards every entry younger than `flushTag` and sets the next tag to `flushTag`+1. It leaves the architectural file untouched. It also overrides any allocation request in the same cycle.
- R11: `headPc` shows the program counter of the oldest live entry.
- R12: Both lookup ports serve the same register at the same time with identical answers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allocCount | input | 3 | Number of entries requested this cycle (0..4) |
| allocDest | input | 12 | Destination register per lane, 3 bits each, lane 0 in bits 2:0 |
| allocPc | input | 4*PCW | Program counter per lane |
| allocTag | output | 16 | Tag given to each lane, 4 bits each |
| allocStall | output | 1 | Request refused for lack of free entries |
| cmpValid | input | 1 | A result is returned this cycle |
| cmpTag | input | 4 | Entry the result belongs to |
| cmpData | input | DW | Result value |
| fwdValid | output | 1 | Forwarding bus carries an accepted result |
| fwdTag | output | 4 | Tag on the forwarding bus |
| fwdData | output | DW | Value on the forwarding bus |
| flushValid | input | 1 | Mispredict recovery request |
| flushTag | input | 4 | Tag of the mispredicted branch |
| lkReg | input | 6 | Source register per lookup port, 3 bits each |
| lkReady | output | 2 | Per port: value is available |
| lkData | output | 2*DW | Per port: operand value |
| lkTag | output | 8 | Per port: substitute tag when not ready |
| retireCnt | output | 3 | Entries leaving the head this cycle |
| headPc | output | PCW | Program counter of the oldest entry |
| archFlat | output | 8*DW | Architectural registers, register r in bits r*DW +: DW |

## Verification
The in-design assertions depend on three conditions at the inputs. `allocCount` never exceeds 4. A flush always names an entry that is live. A result is returned at most once per entry while that entry is live. The stimulus meets these conditions by drawing from the bench's own model of which entries exist and which are still pending. Flush tags are drawn from the live window and completion tags from the pending entries. A deliberate slice of completions aims at free tags to exercise the ignore path. Request sizes stay between 0 and 4.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int RobDepth    = 16;
  localparam int TagW        = $clog2(RobDepth);
  localparam int CntW        = TagW + 1;
  localparam int Lanes       = 4;
  localparam int LaneW       = $clog2(Lanes + 1);
  localparam int NumArch     = 8;
  localparam int RegW        = $clog2(NumArch);
  localparam int LookupPorts = 2;

  typedef logic [TagW-1:0] tag_t;

  // Strobes and pointer state handed from control to datapath.
  typedef struct packed {
    logic            allocEn;
    logic [LaneW-1:0] allocN;
    tag_t            tail;
    tag_t            head;
    logic [CntW-1:0] count;
    logic [LaneW-1:0] retireN;
  } rob_strobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [LaneW-1:0]    allocCount,
  input  logic                flushValid,
  input  tag_t                flushTag,
  input  logic [RobDepth-1:0] doneVec,
  output rob_strobe_t         st,
  output logic                allocStall
);
  tag_t            head, tail;
  logic [CntW-1:0] count, freeCnt, kept;
  logic [LaneW-1:0] retireN;
  logic            allocOk;

  assign freeCnt    = CntW'(RobDepth) - count;
  assign allocStall = CntW'(allocCount) > freeCnt;
  assign allocOk    = !flushValid && !allocStall && (allocCount != '0);
  assign kept       = {1'b0, tag_t'(flushTag - head)} + CntW'(1);

  // Head run of done entries, capped at lane count and at the flush point.
  always_comb begin
    logic stop;
    stop    = 1'b0;
    retireN = '0;
    for (int i = 0; i < Lanes; i++) begin
      if (!stop && (CntW'(i) < count) && doneVec[tag_t'(head + tag_t'(i))] &&
          (!flushValid || (CntW'(i) < kept)))
        retireN = LaneW'(i + 1);
      else
        stop = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head <= head + tag_t'(retireN);
      if (flushValid) begin
        tail  <= tag_t'(flushTag + tag_t'(1));
        count <= kept - CntW'(retireN);
      end else begin
        if (allocOk) tail <= tail + tag_t'(allocCount);
        count <= count - CntW'(retireN) + (allocOk ? CntW'(allocCount) : '0);
      end
    end
  end

  assign st.allocEn = allocOk;
  assign st.allocN  = allocCount;
  assign st.tail    = tail;
  assign st.head    = head;
  assign st.count   = count;
  assign st.retireN = retireN;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CntW'(RobDepth));
  assert_alloc_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    allocCount <= LaneW'(Lanes));
  assert_stall_holds_tail_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!flushValid && allocStall) |=> $stable(tail));
  assert_retire_order_R8: assert property (@(posedge clk) disable iff (!rstN)
    !doneVec[head] |-> (retireN == '0));
  assert_retire_limit_R8: assert property (@(posedge clk) disable iff (!rstN)
    CntW'(retireN) <= count);
  assert_flush_tail_R10: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> (tail == tag_t'($past(flushTag) + tag_t'(1))));
  assert_flush_shrinks_R10: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> (count <= $past(count)));
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DW  = 32,
  parameter int PCW = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rob_strobe_t                 st,
  input  logic [Lanes*RegW-1:0]       allocDest,
  input  logic [Lanes*PCW-1:0]        allocPc,
  input  logic                        cmpValid,
  input  tag_t                        cmpTag,
  input  logic [DW-1:0]               cmpData,
  input  logic [LookupPorts*RegW-1:0] lkReg,
  output logic [RobDepth-1:0]         doneVec,
  output logic [Lanes*TagW-1:0]       allocTag,
  output logic                        fwdValid,
  output tag_t                        fwdTag,
  output logic [DW-1:0]               fwdData,
  output logic [LookupPorts-1:0]      lkReady,
  output logic [LookupPorts*DW-1:0]   lkData,
  output logic [LookupPorts*TagW-1:0] lkTag,
  output logic [PCW-1:0]              headPc,
  output logic [NumArch*DW-1:0]       archFlat
);
  logic [RegW-1:0] destMem [RobDepth];
  logic [PCW-1:0]  pcMem   [RobDepth];
  logic [DW-1:0]   dataMem [RobDepth];
  logic [DW-1:0]   arch    [NumArch];
  logic [DW-1:0]   archNext[NumArch];
  tag_t            allocIdx[Lanes];
  tag_t            retIdx  [Lanes];
  tag_t            cmpOff;
  logic            cmpLive;

  for (genvar i = 0; i < Lanes; i++) begin : g_lane
    assign allocIdx[i] = st.tail + tag_t'(i);
    assign retIdx[i]   = st.head + tag_t'(i);
    assign allocTag[i*TagW +: TagW] = allocIdx[i];
  end

  assign cmpOff   = cmpTag - st.head;
  assign cmpLive  = cmpValid && ({1'b0, cmpOff} < st.count);
  assign fwdValid = cmpLive;
  assign fwdTag   = cmpTag;
  assign fwdData  = cmpData;
  assign headPc   = pcMem[st.head];

  always_ff @(posedge clk) begin
    for (int i = 0; i < Lanes; i++) begin
      if (st.allocEn && (LaneW'(i) < st.allocN)) begin
        destMem[allocIdx[i]] <= allocDest[i*RegW +: RegW];
        pcMem[allocIdx[i]]   <= allocPc[i*PCW +: PCW];
      end
    end
    if (cmpLive) dataMem[cmpTag] <= cmpData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneVec <= '0;
    end else begin
      for (int i = 0; i < Lanes; i++)
        if (st.allocEn && (LaneW'(i) < st.allocN)) doneVec[allocIdx[i]] <= 1'b0;
      if (cmpLive) doneVec[cmpTag] <= 1'b1;
    end
  end

  // Oldest-to-youngest overwrite: the youngest retiring write to a register wins.
  always_comb begin
    archNext = arch;
    for (int i = 0; i < Lanes; i++)
      if (LaneW'(i) < st.retireN) archNext[destMem[retIdx[i]]] = dataMem[retIdx[i]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NumArch; r++) arch[r] <= '0;
    end else begin
      arch <= archNext;
    end
  end

  for (genvar r = 0; r < NumArch; r++) begin : g_arch
    assign archFlat[r*DW +: DW] = arch[r];
  end

  for (genvar p = 0; p < LookupPorts; p++) begin : g_lk
    logic [RegW-1:0] qReg;
    logic            hit;
    tag_t            hitIdx;
    assign qReg = lkReg[p*RegW +: RegW];
    always_comb begin
      hit    = 1'b0;
      hitIdx = '0;
      for (int j = 0; j < RobDepth; j++) begin
        if (!hit && (CntW'(j) < st.count) &&
            (destMem[tag_t'(st.tail - tag_t'(1) - tag_t'(j))] == qReg)) begin
          hit    = 1'b1;
          hitIdx = tag_t'(st.tail - tag_t'(1) - tag_t'(j));
        end
      end
    end
    assign lkReady[p]            = !hit || doneVec[hitIdx];
    assign lkData[p*DW +: DW]    = hit ? dataMem[hitIdx] : arch[qReg];
    assign lkTag[p*TagW +: TagW] = hit ? hitIdx : '0;

    assert_pending_live_R6: assert property (@(posedge clk) disable iff (!rstN)
      !lkReady[p] |-> (st.count != '0));
  end

  assert_cmp_marks_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmpLive |=> doneVec[$past(cmpTag)]);
  assert_arch_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (st.retireN == '0) |=> $stable(archFlat));
endmodule

// File: rtl/rob_rename.sv
module rob_rename
  import rob_pkg::*;
#(
  parameter int DW  = 32,
  parameter int PCW = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [LaneW-1:0]            allocCount,
  input  logic [Lanes*RegW-1:0]       allocDest,
  input  logic [Lanes*PCW-1:0]        allocPc,
  output logic [Lanes*TagW-1:0]       allocTag,
  output logic                        allocStall,
  input  logic                        cmpValid,
  input  logic [TagW-1:0]             cmpTag,
  input  logic [DW-1:0]               cmpData,
  output logic                        fwdValid,
  output logic [TagW-1:0]             fwdTag,
  output logic [DW-1:0]               fwdData,
  input  logic                        flushValid,
  input  logic [TagW-1:0]             flushTag,
  input  logic [LookupPorts*RegW-1:0] lkReg,
  output logic [LookupPorts-1:0]      lkReady,
  output logic [LookupPorts*DW-1:0]   lkData,
  output logic [LookupPorts*TagW-1:0] lkTag,
  output logic [LaneW-1:0]            retireCnt,
  output logic [PCW-1:0]              headPc,
  output logic [NumArch*DW-1:0]       archFlat
);
  rob_strobe_t         st;
  logic [RobDepth-1:0] doneVec;

  rob_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .allocCount(allocCount), .flushValid(flushValid),
    .flushTag(flushTag), .doneVec(doneVec), .st(st), .allocStall(allocStall)
  );

  rob_data #(.DW(DW), .PCW(PCW)) uData (
    .clk(clk), .rstN(rstN), .st(st), .allocDest(allocDest), .allocPc(allocPc),
    .cmpValid(cmpValid), .cmpTag(cmpTag), .cmpData(cmpData), .lkReg(lkReg),
    .doneVec(doneVec), .allocTag(allocTag), .fwdValid(fwdValid), .fwdTag(fwdTag),
    .fwdData(fwdData), .lkReady(lkReady), .lkData(lkData), .lkTag(lkTag),
    .headPc(headPc), .archFlat(archFlat)
  );

  assign retireCnt = st.retireN;
endmodule

// File: tb/rob_rename_test.sv
module rob_rename_test;
  localparam int DW = 32, PCW = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] allocCount = '0;
  logic [11:0] allocDest = '0;
  logic [4*PCW-1:0] allocPc = '0;
  logic [15:0] allocTag;
  logic allocStall;
  logic cmpValid = 1'b0;
  logic [3:0] cmpTag = '0;
  logic [DW-1:0] cmpData = '0;
  logic fwdValid;
  logic [3:0] fwdTag;
  logic [DW-1:0] fwdData;
  logic flushValid = 1'b0;
  logic [3:0] flushTag = '0;
  logic [5:0] lkReg = '0;
  logic [1:0] lkReady;
  logic [2*DW-1:0] lkData;
  logic [7:0] lkTag;
  logic [2:0] retireCnt;
  logic [PCW-1:0] headPc;
  logic [8*DW-1:0] archFlat;

  always #10 clk = ~clk;

  rob_rename #(.DW(DW), .PCW(PCW)) uut (
    .clk(clk), .rstN(rstN), .allocCount(allocCount), .allocDest(allocDest),
    .allocPc(allocPc), .allocTag(allocTag), .allocStall(allocStall),
    .cmpValid(cmpValid), .cmpTag(cmpTag), .cmpData(cmpData), .fwdValid(fwdValid),
    .fwdTag(fwdTag), .fwdData(fwdData), .flushValid(flushValid), .flushTag(flushTag),
    .lkReg(lkReg), .lkReady(lkReady), .lkData(lkData), .lkTag(lkTag),
    .retireCnt(retireCnt), .headPc(headPc), .archFlat(archFlat)
  );

  typedef struct { int dest; logic [PCW-1:0] pc; logic [DW-1:0] data; bit done; } ent_t;
  ent_t q[$];
  int headTag = 0;
  logic [DW-1:0] arch[8];
  int vecs = 0, fails = 0;
  string archReq = "R1";
  int pCmp = 60, pFlush = 4, pBad = 10, dupMode = 0;
  bit finished = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs from the model state, compare, then advance the model at the edge.
  task automatic step(int n);
    int size, tailT, k, kept, off, dupSeen;
    int seen[8];
    size  = q.size();
    tailT = (headTag + size) % 16;
    allocCount = 3'(n);
    for (int i = 0; i < 4; i++) begin
      allocDest[i*3 +: 3] = dupMode ? 3'($urandom_range(0, 1)) : 3'($urandom_range(0, 7));
      allocPc[i*PCW +: PCW] = $urandom;
    end
    cmpValid = 1'b0; off = -1;
    if ($urandom_range(0, 99) < pCmp && size > 0) begin
      int s;
      s = $urandom_range(0, size - 1);
      for (int j = 0; j < size; j++)
        if (off < 0 && !q[(s + j) % size].done) off = (s + j) % size;
      if (off >= 0) begin
        cmpValid = 1'b1; cmpTag = 4'((headTag + off) % 16); cmpData = $urandom;
      end
    end else if ($urandom_range(0, 99) < pBad && size < 16) begin
      cmpValid = 1'b1; cmpTag = 4'((tailT + $urandom_range(0, 15 - size)) % 16); cmpData = $urandom;
    end
    flushValid = 1'b0;
    if (size > 0 && $urandom_range(0, 99) < pFlush) begin
      flushValid = 1'b1; flushTag = 4'((headTag + $urandom_range(0, size - 1)) % 16);
    end
    lkReg[2:0] = 3'($urandom_range(0, 7));
    lkReg[5:3] = ($urandom_range(0, 3) == 0) ? lkReg[2:0] : 3'($urandom_range(0, 7));
    #4;
    // Comparisons at the pre-edge point
    chk("R3", "allocStall", 64'(allocStall), 64'(n > 16 - size));
    for (int i = 0; i < n; i++) chk("R2", "allocTag", 64'(allocTag[i*4 +: 4]), 64'((tailT + i) % 16));
    if (cmpValid && ((cmpTag - headTag + 16) % 16) < size) begin
      chk("R5", "fwdValid", 64'(fwdValid), 64'(1));
      chk("R5", "fwdTag", 64'(fwdTag), 64'(cmpTag));
      chk("R5", "fwdData", 64'(fwdData), 64'(cmpData));
    end else chk("R4", "fwdValid ignored", 64'(fwdValid), 64'(0));
    for (int p = 0; p < 2; p++) begin
      int r, hit;
      r = int'(lkReg[p*3 +: 3]); hit = -1;
      for (int j = size - 1; j >= 0; j--) if (hit < 0 && q[j].dest == r) hit = j;
      if (hit < 0) begin
        chk("R7", "lkReady", 64'(lkReady[p]), 64'(1));
        chk("R7", "lkData", 64'(lkData[p*DW +: DW]), 64'(arch[r]));
      end else if (q[hit].done) begin
        chk("R6", "lkReady", 64'(lkReady[p]), 64'(1));
        chk("R6", "lkData", 64'(lkData[p*DW +: DW]), 64'(q[hit].data));
      end else begin
        chk("R6", "lkReady", 64'(lkReady[p]), 64'(0));
        chk("R6", "lkTag", 64'(lkTag[p*4 +: 4]), 64'((headTag + hit) % 16));
      end
    end
    if (lkReg[2:0] == lkReg[5:3]) begin
      chk("R12", "lkReady pair", 64'(lkReady[1]), 64'(lkReady[0]));
      if (lkReady[0]) chk("R12", "lkData pair", 64'(lkData[2*DW-1:DW]), 64'(lkData[DW-1:0]));
      else chk("R12", "lkTag pair", 64'(lkTag[7:4]), 64'(lkTag[3:0]));
    end
    kept = flushValid ? ((flushTag - headTag + 16) % 16) + 1 : 16;
    k = 0;
    while (k < 4 && k < size && k < kept && q[k].done) k++;
    chk("R8", "retireCnt", 64'(retireCnt), 64'(k));
    if (size > 0) chk("R11", "headPc", 64'(headPc), 64'(q[0].pc));
    for (int r = 0; r < 8; r++) chk(archReq, "arch", 64'(archFlat[r*DW +: DW]), 64'(arch[r]));
    @(posedge clk);
    // Model update
    dupSeen = 0;
    for (int r = 0; r < 8; r++) seen[r] = 0;
    for (int i = 0; i < k; i++) begin
      arch[q[i].dest] = q[i].data;
      if (seen[q[i].dest] != 0) dupSeen = 1;
      seen[q[i].dest] = 1;
    end
    archReq = dupSeen ? "R9" : (flushValid ? "R10" : "R8");
    if (cmpValid && ((cmpTag - headTag + 16) % 16) < size) begin
      q[(cmpTag - headTag + 16) % 16].data = cmpData;
      q[(cmpTag - headTag + 16) % 16].done = 1;
    end
    if (flushValid) while (q.size() > kept) void'(q.pop_back());
    for (int i = 0; i < k; i++) void'(q.pop_front());
    headTag = (headTag + k) % 16;
    if (!flushValid && n <= 16 - size)
      for (int i = 0; i < n; i++) begin
        ent_t e;
        e.dest = int'(allocDest[i*3 +: 3]); e.pc = allocPc[i*PCW +: PCW]; e.data = '0; e.done = 0;
        q.push_back(e);
      end
    @(negedge clk);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) arch[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #4;
    // R1: reset state
    chk("R1", "retireCnt", 64'(retireCnt), 64'(0));
    chk("R1", "archFlat", 64'(archFlat == '0), 64'(1));
    chk("R1", "allocTag lane0", 64'(allocTag[3:0]), 64'(0));
    chk("R1", "lkReady", 64'(lkReady), 64'(2'b11));
    chk("R1", "allocStall", 64'(allocStall), 64'(0));
    @(negedge clk);
    // Fill to capacity without completions, then request more (R3)
    pCmp = 0; pFlush = 0; pBad = 0;
    for (int c = 0; c < 4; c++) step(4);
    step(4); step(1); step(2);
    pBad = 50; step(0); step(0);
    // Mixed traffic
    pCmp = 60; pFlush = 4; pBad = 10;
    for (int c = 0; c < 1500; c++) step($urandom_range(0, 4));
    // Heavy completion with colliding destinations (R9)
    pCmp = 95; pFlush = 1; dupMode = 1;
    for (int c = 0; c < 600; c++) step($urandom_range(1, 4));
    // Frequent mispredicts (R10)
    pCmp = 50; pFlush = 20; dupMode = 0;
    for (int c = 0; c < 400; c++) step($urandom_range(0, 4));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule